// File: doc/BRIEF.md
# Telephone Call Control State Machine

This block follows the call state of one network telephone endpoint. Single-cycle event pulses come in from two sides. From the handset come off-hook, on-hook, dial-symbol and end-of-dialing. From the network come alert, abort, capability query and four call results: rejected, busy, accepted and conditional accept. The block keeps one major state. For the handset it holds a tone or ring selection, and it counts the dial symbols of the current dialing attempt. Toward the call server it issues one-cycle pulses for join conversation, leave conversation and abort.

A hang-up splits into two cases. In a local disconnect the handset ends the call: the block issues a leave and drops to idle. In a remote disconnect the far end or the network ends the call: the handset stays in a waiting state and gets a tone. A timer runs while the handset waits there. When it expires the block goes back to dialing. If the handset hangs up first, the block goes to idle instead. An event that has no meaning in the current state raises an error-report pulse and changes nothing.

All outputs are registered. An event sampled at a clock edge shows its effect on the outputs from that edge on.

Top module: `call_ctrl`

## Requirements
- R1: After reset the state is Idle and the tone is silence, all pulses are low and the dial count is zero. State codes: Idle 0, Parsing 1, Initiating 2, Incoming 3, Conversing 4, LocalDrop 5, RemoteDrop 6. Tone codes: silence 0, dial 1, ringback 2, busy 3, error 4, ring 5.
- R2: In Idle, off-hook moves to Parsing with dial tone. Alert moves to Incoming with ring. Ring is held for the whole time the state stays Incoming.
- R3: In Parsing, a dial symbol keeps the state and selects silence. End-of-dialing moves to Initiating with ringback. On-hook moves to Idle with silence.
- R4: In Initiating, rejected moves to RemoteDrop with error tone and busy moves to RemoteDrop with busy tone. Accepted moves to Conversing with silence and a join pulse. Conditional accept returns to Parsing with silence.
- R5: In Initiating, on-hook moves to LocalDrop with silence and an abort pulse.
- R6: In Incoming, off-hook moves to Conversing with silence and a join pulse. Abort moves to Idle with silence.
- R7: In Conversing, abort moves to RemoteDrop with dial tone. On-hook moves to LocalDrop with silence.
- R8: LocalDrop lasts exactly one cycle. The leave pulse is high during that cycle and the next state is Idle. Events that arrive during that cycle are dropped with no error pulse.
- R9: After TIMEOUT cycles in RemoteDrop the block moves to Parsing with dial tone. On-hook before that moves to Idle with silence. The count starts again on every entry to RemoteDrop.
- R10: A capability query never changes the state or the tone and never raises the error pulse.
- R11: An event with no transition in the current state leaves the state and tone unchanged. The error pulse is high for the one cycle that follows it.
- R12: When several events arrive in one cycle, only the first one in this order is handled: on-hook, off-hook, dial, end-of-dialing, alert, abort, rejected, busy, accepted, conditional, query. In RemoteDrop, timer expiry ranks just below on-hook.
- R13: The dial count clears on every entry to Parsing. It rises by one for each dial symbol handled in Parsing and saturates at 2**CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_onhook | input | 1 | Handset hung up |
| hs_offhook | input | 1 | Handset lifted |
| hs_dial | input | 1 | One dial symbol entered |
| hs_dial_end | input | 1 | Dialing complete |
| nw_alert | input | 1 | Incoming call offered |
| nw_abort | input | 1 | Network cancels call or attempt |
| nw_query | input | 1 | Capability query |
| nw_reject | input | 1 | Call result: rejected |
| nw_busy | input | 1 | Call result: busy |
| nw_accept | input | 1 | Call result: accepted |
| nw_cond | input | 1 | Call result: conditional accept |
| state_o | output | 3 | Current major state code |
| tone_o | output | 3 | Tone or ring selection for the handset |
| dial_cnt_o | output | CNT_W | Dial symbols counted in this attempt |
| join_o | output | 1 | Join-conversation pulse |
| leave_o | output | 1 | Leave-conversation pulse |
| abort_o | output | 1 | Abort pulse toward the server |
| err_o | output | 1 | Error-report pulse |

## Verification
A table of event sequences takes the block through every transition. Each sequence shows whether the right successor state and tone were chosen, and whether each command pulse lands on the right transition. Simultaneous events are applied in pairs whose members disagree on the next state, so the result shows which event won. The block also gets events that are meaningless in the state it is in, and queries. These separate a dropped event from an error report. Directed runs cover the dial-count saturation, the length of the RemoteDrop wait on repeated entries and events arriving during the one-cycle LocalDrop.

// File: rtl/call_pkg.sv
package call_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PARSE = 3'd1,
    ST_INIT  = 3'd2,
    ST_INCOM = 3'd3,
    ST_CONV  = 3'd4,
    ST_DLOC  = 3'd5,
    ST_DREM  = 3'd6
  } call_st_t;

  typedef enum logic [2:0] {
    TN_SILENT   = 3'd0,
    TN_DIAL     = 3'd1,
    TN_RINGBACK = 3'd2,
    TN_BUSY     = 3'd3,
    TN_ERROR    = 3'd4,
    TN_RING     = 3'd5
  } tone_t;

  // event vector positions; a lower index has higher priority
  localparam int NUM_EV     = 11;
  localparam int EV_ONHOOK  = 0;
  localparam int EV_OFFHOOK = 1;
  localparam int EV_DIAL    = 2;
  localparam int EV_END     = 3;
  localparam int EV_ALERT   = 4;
  localparam int EV_ABORT   = 5;
  localparam int EV_REJECT  = 6;
  localparam int EV_BUSY    = 7;
  localparam int EV_ACCEPT  = 8;
  localparam int EV_COND    = 9;
  localparam int EV_QUERY   = 10;

  // saturating increment
  function automatic int unsigned sat_next(int unsigned cur, int unsigned top);
    return (cur >= top) ? top : cur + 1;
  endfunction

  // timer reaches its last cycle in the wait state
  function automatic logic wait_done(int unsigned cnt, int unsigned tmo);
    return (cnt + 1 >= tmo);
  endfunction

endpackage

// File: rtl/call_evsel.sv
module call_evsel #(
  parameter int N = 11
) (
  input  logic [N-1:0] ev_raw,
  output logic [N-1:0] ev_pick
);
  assign ev_pick[0] = ev_raw[0];
  for (genvar i = 1; i < N; i++) begin : g_pri
    assign ev_pick[i] = ev_raw[i] & ~(|ev_raw[i-1:0]);
  end
endmodule

// File: rtl/call_timer.sv
module call_timer
  import call_pkg::*;
#(
  parameter int TMO = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (TMO < 2) ? 1 : $clog2(TMO + 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && wait_done(32'(cnt_q), TMO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/call_fsm.sv
module call_fsm
  import call_pkg::*;
(
  input  call_st_t            cur_st,
  input  logic [NUM_EV-1:0]   ev_pick,
  input  logic                expire,
  output call_st_t            nxt_st,
  output logic                tone_we,
  output tone_t               tone_nv,
  output logic                join_n,
  output logic                abort_n,
  output logic                err_n,
  output logic                dial_clr,
  output logic                dial_inc
);
  logic hit;

  always_comb begin
    nxt_st   = cur_st;
    tone_we  = 1'b0;
    tone_nv  = TN_SILENT;
    join_n   = 1'b0;
    abort_n  = 1'b0;
    dial_clr = 1'b0;
    dial_inc = 1'b0;
    hit      = 1'b0;
    unique case (cur_st)
      ST_IDLE: begin
        if (ev_pick[EV_OFFHOOK]) begin
          nxt_st = ST_PARSE; tone_we = 1'b1; tone_nv = TN_DIAL;
          dial_clr = 1'b1; hit = 1'b1;
        end else if (ev_pick[EV_ALERT]) begin
          nxt_st = ST_INCOM; tone_we = 1'b1; tone_nv = TN_RING; hit = 1'b1;
        end
      end
      ST_PARSE: begin
        if (ev_pick[EV_ONHOOK]) begin
          nxt_st = ST_IDLE; tone_we = 1'b1; hit = 1'b1;
        end else if (ev_pick[EV_DIAL]) begin
          tone_we = 1'b1; dial_inc = 1'b1; hit = 1'b1;
        end else if (ev_pick[EV_END]) begin
          nxt_st = ST_INIT; tone_we = 1'b1; tone_nv = TN_RINGBACK; hit = 1'b1;
        end
      end
      ST_INIT: begin
        if (ev_pick[EV_ONHOOK]) begin
          nxt_st = ST_DLOC; tone_we = 1'b1; abort_n = 1'b1; hit = 1'b1;
        end else if (ev_pick[EV_REJECT]) begin
          nxt_st = ST_DREM; tone_we = 1'b1; tone_nv = TN_ERROR; hit = 1'b1;
        end else if (ev_pick[EV_BUSY]) begin
          nxt_st = ST_DREM; tone_we = 1'b1; tone_nv = TN_BUSY; hit = 1'b1;
        end else if (ev_pick[EV_ACCEPT]) begin
          nxt_st = ST_CONV; tone_we = 1'b1; join_n = 1'b1; hit = 1'b1;
        end else if (ev_pick[EV_COND]) begin
          nxt_st = ST_PARSE; tone_we = 1'b1; dial_clr = 1'b1; hit = 1'b1;
        end
      end
      ST_INCOM: begin
        if (ev_pick[EV_OFFHOOK]) begin
          nxt_st = ST_CONV; tone_we = 1'b1; join_n = 1'b1; hit = 1'b1;
        end else if (ev_pick[EV_ABORT]) begin
          nxt_st = ST_IDLE; tone_we = 1'b1; hit = 1'b1;
        end
      end
      ST_CONV: begin
        if (ev_pick[EV_ONHOOK]) begin
          nxt_st = ST_DLOC; tone_we = 1'b1; hit = 1'b1;
        end else if (ev_pick[EV_ABORT]) begin
          nxt_st = ST_DREM; tone_we = 1'b1; tone_nv = TN_DIAL; hit = 1'b1;
        end
      end
      ST_DLOC: begin
        nxt_st = ST_IDLE; hit = 1'b1;
      end
      ST_DREM: begin
        if (ev_pick[EV_ONHOOK]) begin
          nxt_st = ST_IDLE; tone_we = 1'b1; hit = 1'b1;
        end else if (expire) begin
          nxt_st = ST_PARSE; tone_we = 1'b1; tone_nv = TN_DIAL;
          dial_clr = 1'b1; hit = 1'b1;
        end
      end
      default: begin
        nxt_st = ST_IDLE; hit = 1'b1;
      end
    endcase
  end

  assign err_n = (|ev_pick) && !hit && !ev_pick[EV_QUERY];
endmodule

// File: rtl/call_ctrl.sv
module call_ctrl
  import call_pkg::*;
#(
  parameter int TIMEOUT = 1000,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_onhook,
  input  logic             hs_offhook,
  input  logic             hs_dial,
  input  logic             hs_dial_end,
  input  logic             nw_alert,
  input  logic             nw_abort,
  input  logic             nw_query,
  input  logic             nw_reject,
  input  logic             nw_busy,
  input  logic             nw_accept,
  input  logic             nw_cond,
  output logic [2:0]       state_o,
  output logic [2:0]       tone_o,
  output logic [CNT_W-1:0] dial_cnt_o,
  output logic             join_o,
  output logic             leave_o,
  output logic             abort_o,
  output logic             err_o
);
  localparam int unsigned DIAL_MAX = (1 << CNT_W) - 1;

  logic [NUM_EV-1:0] ev_raw;
  logic [NUM_EV-1:0] ev_pick;
  logic              expire;
  call_st_t          st_q, nxt_st;
  tone_t             tone_q, tone_nv;
  logic              tone_we, join_n, abort_n, err_n, dial_clr, dial_inc;
  logic              join_q, abort_q, err_q;
  logic [CNT_W-1:0]  cnt_q;

  assign ev_raw = {nw_query, nw_cond, nw_accept, nw_busy, nw_reject,
                   nw_abort, nw_alert, hs_dial_end, hs_dial, hs_offhook,
                   hs_onhook};

  call_evsel #(.N(NUM_EV)) u_sel (
    .ev_raw  (ev_raw),
    .ev_pick (ev_pick)
  );

  call_timer #(.TMO(TIMEOUT)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (st_q == ST_DREM),
    .expire (expire)
  );

  call_fsm u_fsm (
    .cur_st   (st_q),
    .ev_pick  (ev_pick),
    .expire   (expire),
    .nxt_st   (nxt_st),
    .tone_we  (tone_we),
    .tone_nv  (tone_nv),
    .join_n   (join_n),
    .abort_n  (abort_n),
    .err_n    (err_n),
    .dial_clr (dial_clr),
    .dial_inc (dial_inc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tone_q  <= TN_SILENT;
      join_q  <= 1'b0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      st_q    <= nxt_st;
      join_q  <= join_n;
      abort_q <= abort_n;
      err_q   <= err_n;
      if (tone_we) tone_q <= tone_nv;
      if (dial_clr)      cnt_q <= '0;
      else if (dial_inc) cnt_q <= CNT_W'(sat_next(32'(cnt_q), DIAL_MAX));
    end
  end

  assign state_o    = st_q;
  assign tone_o     = tone_q;
  assign dial_cnt_o = cnt_q;
  assign join_o     = join_q;
  assign leave_o    = (st_q == ST_DLOC);
  assign abort_o    = abort_q;
  assign err_o      = err_q;
endmodule

// File: rtl/call_ctrl_chk.sv
module call_ctrl_chk
  import call_pkg::*;
#(
  parameter int TMO = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        st,
  input logic [2:0]        tone,
  input logic              join_p,
  input logic              leave_p,
  input logic              abort_p,
  input logic              err_p,
  input logic [NUM_EV-1:0] ev_pick,
  input logic              expire
);
  logic [31:0] dwell_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dwell_q <= '0;
    else if (st == ST_DREM)  dwell_q <= dwell_q + 32'd1;
    else                     dwell_q <= '0;
  end

  // R12
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_pick));

  // R8
  dloc_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_DLOC |=> st == ST_IDLE);

  // R8
  leave_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leave_p |-> ($past(st) == ST_INIT || $past(st) == ST_CONV));

  // R5
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |-> (st == ST_DLOC && leave_p));

  // R4
  join_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    join_p |-> (st == ST_CONV &&
                ($past(st) == ST_INIT || $past(st) == ST_INCOM)));

  // R2
  ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_INCOM |-> tone == TN_RING);

  // R10
  query_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pick[EV_QUERY] && st != ST_DLOC && !expire) |=> ($stable(st) && !err_p));

  // R9
  expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ev_pick[EV_ONHOOK]) |=> (st == ST_PARSE && tone == TN_DIAL));

  // R9
  dwell_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_DREM |-> dwell_q < TMO);

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_p |-> ($stable(st) && $stable(tone)));
endmodule

bind call_ctrl call_ctrl_chk #(.TMO(TIMEOUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .st      (state_o),
  .tone    (tone_o),
  .join_p  (join_o),
  .leave_p (leave_o),
  .abort_p (abort_o),
  .err_p   (err_o),
  .ev_pick (ev_pick),
  .expire  (expire)
);

// File: tb/tb_call_ctrl.sv
`timescale 1ns/1ps
module tb_call_ctrl;
  localparam int TMO = 5;
  localparam int CW  = 3;

  localparam logic [10:0] E_NONE = 11'd0;
  localparam logic [10:0] E_ON   = 11'd1 << 0;
  localparam logic [10:0] E_OFF  = 11'd1 << 1;
  localparam logic [10:0] E_DIAL = 11'd1 << 2;
  localparam logic [10:0] E_END  = 11'd1 << 3;
  localparam logic [10:0] E_ALR  = 11'd1 << 4;
  localparam logic [10:0] E_ABT  = 11'd1 << 5;
  localparam logic [10:0] E_REJ  = 11'd1 << 6;
  localparam logic [10:0] E_BSY  = 11'd1 << 7;
  localparam logic [10:0] E_ACC  = 11'd1 << 8;
  localparam logic [10:0] E_CND  = 11'd1 << 9;
  localparam logic [10:0] E_QRY  = 11'd1 << 10;

  localparam logic [2:0] S_IDLE = 3'd0, S_PARS = 3'd1, S_INIT = 3'd2,
                         S_INC = 3'd3, S_CONV = 3'd4, S_DLOC = 3'd5,
                         S_DREM = 3'd6;
  localparam logic [2:0] T_SIL = 3'd0, T_DIAL = 3'd1, T_RB = 3'd2,
                         T_BUSY = 3'd3, T_ERR = 3'd4, T_RING = 3'd5;

  // {event[10:0], req[3:0], state[2:0], tone[2:0], join, leave, abort, err}
  localparam int NV = 43;
  localparam logic [24:0] TBL [NV] = '{
    {E_OFF,        4'd2,  S_PARS, T_DIAL, 4'b0000}, // R2
    {E_DIAL,       4'd3,  S_PARS, T_SIL,  4'b0000}, // R3
    {E_DIAL,       4'd3,  S_PARS, T_SIL,  4'b0000}, // R3
    {E_END,        4'd3,  S_INIT, T_RB,   4'b0000}, // R3
    {E_ACC,        4'd4,  S_CONV, T_SIL,  4'b1000}, // R4
    {E_QRY,        4'd10, S_CONV, T_SIL,  4'b0000}, // R10
    {E_DIAL,       4'd11, S_CONV, T_SIL,  4'b0001}, // R11
    {E_ON,         4'd7,  S_DLOC, T_SIL,  4'b0100}, // R7
    {E_NONE,       4'd8,  S_IDLE, T_SIL,  4'b0000}, // R8
    {E_ALR,        4'd2,  S_INC,  T_RING, 4'b0000}, // R2
    {E_DIAL,       4'd11, S_INC,  T_RING, 4'b0001}, // R11
    {E_OFF,        4'd6,  S_CONV, T_SIL,  4'b1000}, // R6
    {E_ABT,        4'd7,  S_DREM, T_DIAL, 4'b0000}, // R7
    {E_NONE,       4'd9,  S_DREM, T_DIAL, 4'b0000}, // R9
    {E_NONE,       4'd9,  S_DREM, T_DIAL, 4'b0000}, // R9
    {E_NONE,       4'd9,  S_DREM, T_DIAL, 4'b0000}, // R9
    {E_NONE,       4'd9,  S_DREM, T_DIAL, 4'b0000}, // R9
    {E_NONE,       4'd9,  S_PARS, T_DIAL, 4'b0000}, // R9
    {E_END,        4'd3,  S_INIT, T_RB,   4'b0000}, // R3
    {E_BSY,        4'd4,  S_DREM, T_BUSY, 4'b0000}, // R4
    {E_ON,         4'd9,  S_IDLE, T_SIL,  4'b0000}, // R9
    {E_OFF,        4'd2,  S_PARS, T_DIAL, 4'b0000}, // R2
    {E_END,        4'd3,  S_INIT, T_RB,   4'b0000}, // R3
    {E_REJ,        4'd4,  S_DREM, T_ERR,  4'b0000}, // R4
    {E_ON,         4'd9,  S_IDLE, T_SIL,  4'b0000}, // R9
    {E_OFF,        4'd2,  S_PARS, T_DIAL, 4'b0000}, // R2
    {E_END,        4'd3,  S_INIT, T_RB,   4'b0000}, // R3
    {E_CND,        4'd4,  S_PARS, T_SIL,  4'b0000}, // R4
    {E_END,        4'd3,  S_INIT, T_RB,   4'b0000}, // R3
    {E_ON,         4'd5,  S_DLOC, T_SIL,  4'b0110}, // R5
    {E_NONE,       4'd8,  S_IDLE, T_SIL,  4'b0000}, // R8
    {E_ALR,        4'd2,  S_INC,  T_RING, 4'b0000}, // R2
    {E_ABT,        4'd6,  S_IDLE, T_SIL,  4'b0000}, // R6
    {E_ON,         4'd11, S_IDLE, T_SIL,  4'b0001}, // R11
    {E_OFF|E_ALR,  4'd12, S_PARS, T_DIAL, 4'b0000}, // R12
    {E_ON|E_QRY,   4'd12, S_IDLE, T_SIL,  4'b0000}, // R12
    {E_QRY,        4'd10, S_IDLE, T_SIL,  4'b0000}, // R10
    {E_OFF,        4'd2,  S_PARS, T_DIAL, 4'b0000}, // R2
    {E_DIAL|E_END, 4'd12, S_PARS, T_SIL,  4'b0000}, // R12
    {E_END,        4'd3,  S_INIT, T_RB,   4'b0000}, // R3
    {E_ACC|E_ON,   4'd12, S_DLOC, T_SIL,  4'b0110}, // R12
    {E_NONE,       4'd8,  S_IDLE, T_SIL,  4'b0000}, // R8
    {E_ACC,        4'd11, S_IDLE, T_SIL,  4'b0001}  // R11
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_onhook = 0, hs_offhook = 0, hs_dial = 0, hs_dial_end = 0;
  logic nw_alert = 0, nw_abort = 0, nw_query = 0, nw_reject = 0;
  logic nw_busy = 0, nw_accept = 0, nw_cond = 0;
  logic [2:0]    state_o, tone_o;
  logic [CW-1:0] dial_cnt_o;
  logic          join_o, leave_o, abort_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  call_ctrl #(.TIMEOUT(TMO), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .hs_onhook(hs_onhook), .hs_offhook(hs_offhook), .hs_dial(hs_dial),
    .hs_dial_end(hs_dial_end), .nw_alert(nw_alert), .nw_abort(nw_abort),
    .nw_query(nw_query), .nw_reject(nw_reject), .nw_busy(nw_busy),
    .nw_accept(nw_accept), .nw_cond(nw_cond),
    .state_o(state_o), .tone_o(tone_o), .dial_cnt_o(dial_cnt_o),
    .join_o(join_o), .leave_o(leave_o), .abort_o(abort_o), .err_o(err_o)
  );

  task automatic set_ev(input logic [10:0] e);
    hs_onhook = e[0]; hs_offhook = e[1]; hs_dial = e[2]; hs_dial_end = e[3];
    nw_alert = e[4]; nw_abort = e[5]; nw_reject = e[6]; nw_busy = e[7];
    nw_accept = e[8]; nw_cond = e[9]; nw_query = e[10];
  endtask

  // one event cycle, then sample at the following falling edge
  task automatic step(input logic [10:0] e);
    set_ev(e);
    @(posedge clk);
    @(negedge clk);
    set_ev(E_NONE);
  endtask

  task automatic chk(input string req, input logic [9:0] exp_v);
    logic [9:0] act;
    act = {state_o, tone_o, join_o, leave_o, abort_o, err_o};
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: st/tone/jlae actual %0d/%0d/%b expected %0d/%0d/%b",
               req, act[9:7], act[6:4], act[3:0],
               exp_v[9:7], exp_v[6:4], exp_v[3:0]);
    end
  endtask

  task automatic chk_cnt(input string req, input int exp_c);
    n_chk++;
    if (int'(dial_cnt_o) != exp_c) begin
      n_fail++;
      $display("FAIL %s: dial count actual %0d expected %0d",
               req, dial_cnt_o, exp_c);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {S_IDLE, T_SIL, 4'b0000});
    chk_cnt("R1", 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {S_IDLE, T_SIL, 4'b0000});

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][24:14]);
      chk($sformatf("R%0d", TBL[i][13:10]), TBL[i][9:0]);
    end

    // R13 dial count: clear on entry, count, saturate
    step(E_OFF);
    chk_cnt("R13", 0);
    for (int k = 0; k < 3; k++) step(E_DIAL);
    chk_cnt("R13", 3);
    for (int k = 0; k < 6; k++) step(E_DIAL);
    chk_cnt("R13", 7);
    step(E_END);
    step(E_CND);
    chk("R4", {S_PARS, T_SIL, 4'b0000});
    chk_cnt("R13", 0);
    step(E_DIAL);
    chk_cnt("R13", 1);

    // R9 full wait again on a later entry
    step(E_END);
    step(E_BSY);
    chk("R9", {S_DREM, T_BUSY, 4'b0000});
    for (int k = 0; k < TMO - 1; k++) begin
      step(E_NONE);
      chk("R9", {S_DREM, T_BUSY, 4'b0000});
    end
    step(E_NONE);
    chk("R9", {S_PARS, T_DIAL, 4'b0000});
    chk_cnt("R13", 0);

    // R9 hang-up part way through the wait, then re-entry waits in full
    step(E_END);
    step(E_REJ);
    step(E_NONE);
    step(E_ON);
    chk("R9", {S_IDLE, T_SIL, 4'b0000});
    step(E_OFF);
    step(E_END);
    step(E_REJ);
    for (int k = 0; k < TMO - 1; k++) step(E_NONE);
    chk("R9", {S_DREM, T_ERR, 4'b0000});
    step(E_NONE);
    chk("R9", {S_PARS, T_DIAL, 4'b0000});

    // R8 event during the one-cycle local drop is dropped without error
    step(E_END);
    step(E_ON);
    chk("R5", {S_DLOC, T_SIL, 4'b0110});
    step(E_OFF);
    chk("R8", {S_IDLE, T_SIL, 4'b0000});
    step(E_NONE);
    chk("R8", {S_IDLE, T_SIL, 4'b0000});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule